// File: doc/BRIEF.md
# Four-Channel Residue Arithmetic Unit

This block computes in a residue number system built on the coprime moduli 8, 7, 5 and 3, whose product gives 840 distinct values. A number is carried as a tuple of four small residues, one per modulus. Addition, subtraction, multiplication and negation run in each channel on its own, with no carry passing between channels, so the arithmetic depth is set by the widest channel rather than by the full word.

The same unit converts in both directions. A binary integer is split into its four remainders, and a tuple is turned back into binary by summing each residue times a fixed reconstruction weight and reducing modulo 840. Every accepted operation produces both the result tuple and its binary value one clock later, flagged by a valid strobe. Between strobes the outputs hold.

Top module: `rns_alu`

## Requirements
- R1: While reset is asserted and after its release until the first accepted operation, valid_out, res_out and bin_out are all zero.
- R2: Opcode 0 (add) returns, channel by channel, (a + b) mod m; the tuple layout on res_a, res_b and res_out is bits [10:8] mod-8 residue, [7:5] mod-7, [4:2] mod-5, [1:0] mod-3, and every result residue is below its modulus.
- R3: Opcode 1 (subtract) returns (a − b) mod m in each channel, wrapping below zero (0 − 1 gives 839 in binary).
- R4: Opcode 2 (multiply) returns (a × b) mod m in each channel (839 × 839 gives 1).
- R5: Opcode 3 (negate) returns (m − a) mod m in each channel, ignoring res_b; negating zero gives zero.
- R6: Opcode 4 (binary to residue) returns the remainders of bin_in modulo 840 by 8, 7, 5 and 3; inputs from 840 to 1023 are first reduced by 840.
- R7: Opcode 5 (residue to binary) passes res_a to res_out and gives on bin_out the sum of the residues weighted by 105, 120, 336 and 280 (mod-8, mod-7, mod-5, mod-3 channel), reduced modulo 840; the tuple (1|2|4|0) gives 9.
- R8: Whenever valid_out is high, bin_out is the value in 0 to 839 whose residues are res_out.
- R9: valid_out is high in exactly the cycle after each cycle in which valid_in is sampled high, carrying that operation's result.
- R10: Opcodes 6 and 7 are reserved and return the all-zero tuple and binary 0 with valid_out high.
- R11: When valid_in is low, res_out and bin_out keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operation accepted this cycle |
| opcode | input | 3 | 0 add, 1 sub, 2 mul, 3 neg, 4 to residue, 5 to binary, 6–7 reserved |
| res_a | input | 11 | First operand tuple |
| res_b | input | 11 | Second operand tuple |
| bin_in | input | 10 | Binary input for opcode 4 |
| valid_out | output | 1 | Result present |
| res_out | output | 11 | Result tuple |
| bin_out | output | 10 | Binary value of res_out |

## Verification
The moduli set is fixed, so the bench builds the unit with its default widths: 3-bit residues for 8, 7 and 5, a 2-bit residue for 3 and a 10-bit binary side. At this size every binary input from 0 to 1023 and every tuple of the 840-value range are driven through the two conversions exhaustively, covering the wrap above 839. The four channel-wise operations are driven with several thousand random operand pairs each plus the wrap corners, and each result is compared with the integer result modulo 840, which exercises the end-around fold of the mod-7 and mod-3 channels at every operand value.

// File: rtl/rns_pkg.sv
package rns_pkg;
    localparam int BIN_W   = 10;
    localparam int RANGE   = 840;
    localparam int SUM_W   = 12;
    localparam int TUPLE_W = 11;

    typedef struct packed {
        logic [2:0] r8;
        logic [2:0] r7;
        logic [2:0] r5;
        logic [1:0] r3;
    } rns_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_NEG  = 3'd3,
        OP_FWD  = 3'd4,
        OP_REV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_t;
endpackage

// File: rtl/rns_channel.sv
module rns_channel
    import rns_pkg::*;
#(
    parameter int MOD = 7,
    parameter int W   = 3
) (
    input  op_t          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W;

    generate
        if (MOD == (1 << W)) begin : g_pow2
            // power-of-two modulus: keep the low bits
            always_comb begin
                case (op)
                    OP_ADD:  y = a + b;
                    OP_SUB:  y = a - b;
                    OP_MUL:  y = a * b;
                    OP_NEG:  y = '0 - a;
                    default: y = '0;
                endcase
            end
        end else if (MOD == (1 << W) - 1) begin : g_fold
            // modulus 2^W-1: end-around fold of the high half
            localparam logic [PW-1:0] MODV = PW'(MOD);
            logic [PW-1:0] ax_d, bx_d, raw_d;
            logic [W:0]    s_d;
            logic [W-1:0]  t_d;
            always_comb begin
                ax_d = {{W{1'b0}}, a};
                bx_d = {{W{1'b0}}, b};
                case (op)
                    OP_ADD:  raw_d = ax_d + bx_d;
                    OP_SUB:  raw_d = ax_d + MODV - bx_d;
                    OP_MUL:  raw_d = ax_d * bx_d;
                    OP_NEG:  raw_d = MODV - ax_d;
                    default: raw_d = '0;
                endcase
                s_d = {1'b0, raw_d[PW-1:W]} + {1'b0, raw_d[W-1:0]};
                t_d = s_d[W-1:0] + {{(W-1){1'b0}}, s_d[W]};
                y   = (t_d == W'(MOD)) ? '0 : t_d;
            end
        end else begin : g_generic
            localparam logic [PW-1:0] MODV = PW'(MOD);
            logic [PW-1:0] ax_d, bx_d, raw_d;
            always_comb begin
                ax_d = {{W{1'b0}}, a};
                bx_d = {{W{1'b0}}, b};
                case (op)
                    OP_ADD:  raw_d = ax_d + bx_d;
                    OP_SUB:  raw_d = ax_d + MODV - bx_d;
                    OP_MUL:  raw_d = ax_d * bx_d;
                    OP_NEG:  raw_d = MODV - ax_d;
                    default: raw_d = '0;
                endcase
                y = W'(raw_d % MODV);
            end
        end
    endgenerate
endmodule

// File: rtl/rns_fwd.sv
module rns_fwd
    import rns_pkg::*;
(
    input  logic [BIN_W-1:0] bin,
    output rns_t             res
);
    logic [BIN_W-1:0] red_d;

    always_comb begin
        red_d  = (bin >= BIN_W'(RANGE)) ? bin - BIN_W'(RANGE) : bin;
        res.r8 = 3'(red_d % BIN_W'(8));
        res.r7 = 3'(red_d % BIN_W'(7));
        res.r5 = 3'(red_d % BIN_W'(5));
        res.r3 = 2'(red_d % BIN_W'(3));
    end
endmodule

// File: rtl/rns_rev.sv
module rns_rev
    import rns_pkg::*;
(
    input  rns_t             res,
    output logic [BIN_W-1:0] bin
);
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = SUM_W'(res.r8) * SUM_W'(105)
              + SUM_W'(res.r7) * SUM_W'(120)
              + SUM_W'(res.r5) * SUM_W'(336)
              + SUM_W'(res.r3) * SUM_W'(280);
        bin   = BIN_W'(sum_d % SUM_W'(RANGE));
    end
endmodule

// File: rtl/rns_alu.sv
module rns_alu
    import rns_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [2:0]         opcode,
    input  logic [TUPLE_W-1:0] res_a,
    input  logic [TUPLE_W-1:0] res_b,
    input  logic [BIN_W-1:0]   bin_in,
    output logic               valid_out,
    output logic [TUPLE_W-1:0] res_out,
    output logic [BIN_W-1:0]   bin_out
);
    typedef struct packed {
        logic             valid;
        rns_t             res;
        logic [BIN_W-1:0] bin;
    } state_t;

    state_t st_d, st_q;
    op_t    op;
    rns_t   a_t, b_t, ch_t, fwd_t, sel_d;
    logic [BIN_W-1:0] rev_bin;

    assign op  = op_t'(opcode);
    assign a_t = rns_t'(res_a);
    assign b_t = rns_t'(res_b);

    rns_channel #(.MOD(8), .W(3)) u_ch8 (.op(op), .a(a_t.r8), .b(b_t.r8), .y(ch_t.r8));
    rns_channel #(.MOD(7), .W(3)) u_ch7 (.op(op), .a(a_t.r7), .b(b_t.r7), .y(ch_t.r7));
    rns_channel #(.MOD(5), .W(3)) u_ch5 (.op(op), .a(a_t.r5), .b(b_t.r5), .y(ch_t.r5));
    rns_channel #(.MOD(3), .W(2)) u_ch3 (.op(op), .a(a_t.r3), .b(b_t.r3), .y(ch_t.r3));

    rns_fwd u_fwd (.bin(bin_in), .res(fwd_t));

    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_NEG: sel_d = ch_t;
            OP_FWD:                         sel_d = fwd_t;
            OP_REV:                         sel_d = a_t;
            default:                        sel_d = '0;
        endcase
    end

    rns_rev u_rev (.res(sel_d), .bin(rev_bin));

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            st_d.res = sel_d;
            st_d.bin = rev_bin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out = st_q.valid;
    assign res_out   = st_q.res;
    assign bin_out   = st_q.bin;

    // R2: channel results stay canonical
    assert_canonical_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (st_q.res.r7 != 3'd7 && st_q.res.r5 < 3'd5 && st_q.res.r3 != 2'd3));

    // R8: binary side stays inside the range
    assert_bin_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (bin_out < BIN_W'(RANGE)));

    // R6 with R7: forward then reverse conversion returns the input
    assert_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && opcode == 3'd4 && bin_in < BIN_W'(RANGE)) |=> (bin_out == $past(bin_in)));

    // R9: one-cycle latency of the strobe
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    // R11: outputs hold while idle
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(res_out) && $stable(bin_out)));
endmodule

// File: tb/tb_rns_alu.sv
`timescale 1ns/1ps
module tb_rns_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [2:0]  opcode = '0;
    logic [10:0] res_a = '0;
    logic [10:0] res_b = '0;
    logic [9:0]  bin_in = '0;
    logic        valid_out;
    logic [10:0] res_out;
    logic [9:0]  bin_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [10:0] res;
        logic [9:0]  bin;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [10:0] last_res = '0;
    logic [9:0]  last_bin = '0;

    always #2.5 clk = ~clk;

    rns_alu dut (.clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
                 .res_a(res_a), .res_b(res_b), .bin_in(bin_in),
                 .valid_out(valid_out), .res_out(res_out), .bin_out(bin_out));

    function automatic logic [10:0] mk(int v);
        return {3'(v % 8), 3'(v % 7), 3'(v % 5), 2'(v % 3)};
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic drive(int op, logic [10:0] a, logic [10:0] b, int bn, int z, string tag);
        exp_t e;
        @(negedge clk);
        valid_in = 1'b1;
        opcode   = 3'(op);
        res_a    = a;
        res_b    = b;
        bin_in   = 10'(bn);
        if (op >= 6) begin
            e.res = '0;
            e.bin = '0;
        end else begin
            e.res = mk(z);
            e.bin = 10'(z);
        end
        e.tag = tag;
        sb.push_back(e);
        last_res = e.res;
        last_bin = e.bin;
    endtask

    task automatic arith(int op, int x, int y, string tag);
        int z;
        case (op)
            0: z = (x + y) % 840;
            1: z = (x - y + 840) % 840;
            2: z = (x * y) % 840;
            default: z = (840 - x) % 840;
        endcase
        drive(op, mk(x), mk(y), 0, z, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            opcode   = 3'(i);
            res_a    = 11'($urandom);
            res_b    = 11'($urandom);
            bin_in   = 10'($urandom);
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(valid_out == valid_in, "R9 strobe", int'(valid_out), int'(valid_in));
            if (valid_out) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(res_out == e.res, {e.tag, " tuple"}, int'(res_out), int'(e.res));
                    check(bin_out == e.bin, {e.tag, " binary R8"}, int'(bin_out), int'(e.bin));
                end
            end
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_out == 1'b0, "R1 valid", int'(valid_out), 0);
        check(res_out == '0, "R1 tuple", int'(res_out), 0);
        check(bin_out == '0, "R1 binary", int'(bin_out), 0);
        rst_n = 1'b1;
        idle(2);
        check(res_out == '0 && bin_out == '0, "R1 after release", int'(res_out), 0);

        // R7: weighted reconstruction example
        drive(5, {3'd1, 3'd2, 3'd4, 2'd0}, '0, 0, 9, "R7 example");
        // boundary cases
        arith(0, 839, 1, "R2 wrap");
        arith(0, 839, 839, "R2 wrap high");
        arith(1, 0, 1, "R3 borrow");
        arith(1, 5, 5, "R3 zero");
        arith(2, 839, 839, "R4 corner");
        arith(2, 0, 839, "R4 zero");
        arith(3, 0, 0, "R5 zero");
        drive(3, mk(1), mk(500), 0, 839, "R5 ignore b");
        drive(6, mk(123), mk(45), 77, 0, "R10 op6");
        drive(7, mk(400), mk(3), 900, 0, "R10 op7");

        // R11: outputs hold while idle with busy inputs
        drive(0, mk(100), mk(200), 0, 300, "R2 before hold");
        idle(4);
        check(res_out == last_res, "R11 tuple hold", int'(res_out), int'(last_res));
        check(bin_out == last_bin, "R11 binary hold", int'(bin_out), int'(last_bin));

        // random arithmetic
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 2500; i++) begin
                int x, y;
                x = int'($urandom % 840);
                y = int'($urandom % 840);
                case (op)
                    0: arith(op, x, y, "R2 add");
                    1: arith(op, x, y, "R3 sub");
                    2: arith(op, x, y, "R4 mul");
                    default: arith(op, x, y, "R5 neg");
                endcase
                if (i % 97 == 0) idle(1);
            end
        end

        // exhaustive forward conversion, including 840..1023
        for (int v = 0; v < 1024; v++) drive(4, '0, '0, v, v % 840, "R6 forward");
        idle(2);
        // exhaustive reverse conversion
        for (int v = 0; v < 840; v++) drive(5, mk(v), mk(839 - v), 0, v, "R7 reverse");
        idle(4);

        check(sb.size() == 0, "R9 drained", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule